// File: doc/BRIEF.md
# Scrolling Text Frame Engine

This block turns a store of pre-encoded text columns into a stream of LED row bytes for a chain of 8x8 matrices. A window as wide as the chain (four matrices, 32 columns by default) sits over one text string. At the end of every refresh the window moves one column left, moves one column right, or stays where it is. The choice comes from a mode input. A speed setting gives how many refreshes each window position is shown before it moves. Scrolling wraps around the string, so a column that leaves one edge comes back in at the other edge.

Each refresh is a burst of row bytes sent over a valid/ready stream to a serial driver. The byte order is row 0 for matrices 0..3, then row 1, and so on up to row 7. Matrix 0 holds the leftmost columns, and bit 7 of a byte is the leftmost column of that matrix. A byte is held, together with its row and matrix tags, for as long as the driver keeps ready low. After the last byte of a burst the stream stays idle until the driver pulses `drv_done`. Window position, string choice and blanking change only at that boundary, so a frame is never torn.

Control pins are single-cycle pulses:
- raise or lower the speed;
- step the brightness;
- toggle blinking;
- select the next string.

Brightness changes are reported to the driver on a separate update strobe. Columns are written through a plain write port. Any frame that uses a written column shows the new bitmap at once, so loading is done while the stream is stalled or idle.

Top module: `sfe_scroll_engine`

## Requirements
- R1: A frame is 32 bytes, sent in the order byte k = row (k/4), matrix (k%4). `frm_last` is high only on the byte for row 7, matrix 3. Bit b of a byte is pixel row `frm_row` of string column (off + 8*mat + 7 - b) mod 64, and that pixel is bit `frm_row` of the stored column byte.
- R2: `scroll_mode` = 1 (left) adds one to the window offset at each step, wrapping from 63 to 0.
- R3: `scroll_mode` = 2 (right) subtracts one from the window offset at each step, wrapping from 0 to 63.
- R4: `scroll_mode` = 0 or 3 (hold) keeps the offset, so the same frame is sent again.
- R5: With speed S, each window position is sent in exactly S consecutive frames. A step happens at every S-th frame boundary.
- R6: Speed resets to 4 and stays between 1 and 15. A lower pulse at 1 or a raise pulse at 15 has no effect.
- R7: Each `bright_up` pulse steps the 4-bit level by one, wrapping 15 to 0. On the next cycle `lvl_upd` pulses for one cycle with the new level on `lvl_val`. The level resets to 0.
- R8: A `str_next` pulse takes effect at the next frame boundary. It selects the next string (wrapping after the last one) and restarts the window at offset 0 with a fresh repeat count.
- R9: A `blink_tgl` pulse takes effect at the next frame boundary and switches blinking. While blinking is on, the window positions alternate between normal and all-zero frames, starting with a normal position.
- R10: While `frm_valid` is high and `frm_ready` is low, the byte and its tags stay fixed. After the last byte is accepted, `frm_valid` stays low until `drv_done` is seen. `drv_done` has no effect while a frame is streaming.
- R11: After reset, `frm_valid` is high on byte 0 (row 0, matrix 0) of string 0 at offset 0, `lvl_val` is 0 and `lvl_upd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_we | input | 1 | Column write strobe |
| col_wstr | input | 1 | String index of the written column |
| col_wcol | input | 6 | Column index within the string |
| col_wdata | input | 8 | Column bitmap, bit r is pixel row r |
| scroll_mode | input | 2 | 0/3 hold, 1 left, 2 right |
| speed_up | input | 1 | Pulse: one more refresh per position |
| speed_dn | input | 1 | Pulse: one fewer refresh per position |
| bright_up | input | 1 | Pulse: next brightness level |
| blink_tgl | input | 1 | Pulse: toggle blinking |
| str_next | input | 1 | Pulse: select next string |
| frm_valid | output | 1 | Row byte available |
| frm_ready | input | 1 | Driver accepts the byte |
| frm_data | output | 8 | Row byte |
| frm_row | output | 3 | Row of the byte |
| frm_mat | output | 2 | Matrix of the byte |
| frm_last | output | 1 | Last byte of the frame |
| drv_done | input | 1 | Driver has finished the frame |
| lvl_upd | output | 1 | Brightness update strobe |
| lvl_val | output | 4 | Brightness level |

## Verification
The bench targets the offset wraps at both ends of the string. A design that wrapped wrongly would show a column of another string, or garbage, in the window. It drives the speed to both clamps and counts frames per position. Missing saturation would wrap the repeat counter and give a position 0 or 16 refreshes. String select and blink toggles are issued between frames and checked to land only at the next boundary, with the blank position second; a design that applied them at once or got the phase wrong would blank the wrong frames. Brightness wrap, stream stall stability and the idle gap before `drv_done` are checked directly at the pins.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int ROW_N    = 8;
  localparam int MAT_COLS = 8;

  typedef enum logic [1:0] {
    MODE_HOLD     = 2'd0,
    MODE_LEFT     = 2'd1,
    MODE_RIGHT    = 2'd2,
    MODE_HOLD_ALT = 2'd3
  } scroll_mode_e;

  typedef enum logic {
    ST_SEND = 1'b0,
    ST_WAIT = 1'b1
  } frm_state_e;
endpackage

// File: rtl/sfe_colbuf.sv
module sfe_colbuf #(
  parameter int STR_N    = 2,
  parameter int STR_COLS = 64,
  parameter int MAT_N    = 4,
  localparam int STR_W  = $clog2(STR_N),
  localparam int COL_W  = $clog2(STR_COLS),
  localparam int MAT_W  = $clog2(MAT_N),
  localparam int ADDR_W = $clog2(STR_N * STR_COLS),
  localparam int SUM_W  = COL_W + 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [STR_W-1:0] wstr,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  input  logic [STR_W-1:0] rd_str,
  input  logic [COL_W-1:0] rd_off,
  input  logic [MAT_W-1:0] rd_mat,
  input  logic [2:0]       rd_row,
  output logic [7:0]       rd_byte
);
  logic [7:0] mem [STR_N*STR_COLS];
  logic [ADDR_W-1:0] waddr;

  assign waddr = ADDR_W'(wstr) * ADDR_W'(STR_COLS) + ADDR_W'(wcol);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar b = 0; b < sfe_pkg::MAT_COLS; b++) begin : g_bit
    logic [SUM_W-1:0]  sum_b;
    logic [COL_W-1:0]  col_b;
    logic [ADDR_W-1:0] addr_b;
    logic [7:0]        colv_b;
    assign sum_b  = SUM_W'(rd_off) + SUM_W'({rd_mat, 3'b000}) + SUM_W'(7 - b);
    assign col_b  = (sum_b >= SUM_W'(STR_COLS)) ? COL_W'(sum_b - SUM_W'(STR_COLS))
                                                : COL_W'(sum_b);
    assign addr_b = ADDR_W'(rd_str) * ADDR_W'(STR_COLS) + ADDR_W'(col_b);
    assign colv_b = mem[addr_b];
    assign rd_byte[b] = colv_b[rd_row];
  end
endmodule

// File: rtl/sfe_levels.sv
module sfe_levels #(
  parameter int SPD_MAX  = 15,
  parameter int SPD_INIT = 4,
  parameter int LVL_W    = 4,
  localparam int SPD_W = $clog2(SPD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             speed_up,
  input  logic             speed_dn,
  input  logic             bright_up,
  output logic [SPD_W-1:0] spd,
  output logic             lvl_upd,
  output logic [LVL_W-1:0] lvl_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd <= SPD_W'(SPD_INIT);
    end else if (speed_up && !speed_dn && spd < SPD_W'(SPD_MAX)) begin
      spd <= spd + SPD_W'(1);
    end else if (speed_dn && !speed_up && spd > SPD_W'(1)) begin
      spd <= spd - SPD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_val <= '0;
      lvl_upd <= 1'b0;
    end else begin
      lvl_upd <= bright_up;
      if (bright_up) lvl_val <= lvl_val + LVL_W'(1);
    end
  end
endmodule

// File: rtl/sfe_pacer.sv
module sfe_pacer #(
  parameter int STR_N    = 2,
  parameter int STR_COLS = 64,
  parameter int SPD_MAX  = 15,
  localparam int STR_W = $clog2(STR_N),
  localparam int COL_W = $clog2(STR_COLS),
  localparam int SPD_W = $clog2(SPD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [1:0]       mode,
  input  logic [SPD_W-1:0] spd,
  input  logic             str_next,
  input  logic             blink_tgl,
  output logic [COL_W-1:0] off,
  output logic [STR_W-1:0] str_sel,
  output logic             blank
);
  import sfe_pkg::*;

  logic [SPD_W-1:0] rep;
  logic             str_pend, blink_pend, blink_on, phase;
  logic             step;
  logic [COL_W-1:0] off_nxt;

  assign step  = (SPD_W'(rep + SPD_W'(1)) >= spd);
  assign blank = blink_on & phase;

  always_comb begin
    unique case (scroll_mode_e'(mode))
      MODE_LEFT:  off_nxt = (off == COL_W'(STR_COLS - 1)) ? '0 : off + COL_W'(1);
      MODE_RIGHT: off_nxt = (off == '0) ? COL_W'(STR_COLS - 1) : off - COL_W'(1);
      default:    off_nxt = off;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off        <= '0;
      str_sel    <= '0;
      rep        <= '0;
      str_pend   <= 1'b0;
      blink_pend <= 1'b0;
      blink_on   <= 1'b0;
      phase      <= 1'b0;
    end else if (boundary) begin
      if (str_pend) begin
        str_sel <= (str_sel == STR_W'(STR_N - 1)) ? '0 : str_sel + STR_W'(1);
        off     <= '0;
        rep     <= '0;
      end else if (step) begin
        rep   <= '0;
        off   <= off_nxt;
        phase <= ~phase;
      end else begin
        rep <= rep + SPD_W'(1);
      end
      if (blink_pend) begin
        blink_on <= ~blink_on;
        phase    <= 1'b0;
      end
      str_pend   <= str_next;
      blink_pend <= blink_tgl;
    end else begin
      if (str_next)  str_pend   <= 1'b1;
      if (blink_tgl) blink_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/sfe_scroll_engine.sv
module sfe_scroll_engine #(
  parameter int STR_N    = 2,
  parameter int STR_COLS = 64,
  parameter int MAT_N    = 4,
  parameter int SPD_MAX  = 15,
  parameter int SPD_INIT = 4,
  parameter int LVL_W    = 4,
  localparam int STR_W  = $clog2(STR_N),
  localparam int COL_W  = $clog2(STR_COLS),
  localparam int MAT_W  = $clog2(MAT_N),
  localparam int SPD_W  = $clog2(SPD_MAX + 1),
  localparam int BYTE_N = MAT_N * sfe_pkg::ROW_N,
  localparam int IDX_W  = $clog2(BYTE_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_we,
  input  logic [STR_W-1:0] col_wstr,
  input  logic [COL_W-1:0] col_wcol,
  input  logic [7:0]       col_wdata,
  input  logic [1:0]       scroll_mode,
  input  logic             speed_up,
  input  logic             speed_dn,
  input  logic             bright_up,
  input  logic             blink_tgl,
  input  logic             str_next,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [7:0]       frm_data,
  output logic [2:0]       frm_row,
  output logic [MAT_W-1:0] frm_mat,
  output logic             frm_last,
  input  logic             drv_done,
  output logic             lvl_upd,
  output logic [LVL_W-1:0] lvl_val
);
  import sfe_pkg::*;

  frm_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [SPD_W-1:0] spd_q;
  logic [COL_W-1:0] off;
  logic [STR_W-1:0] str_sel;
  logic             blank;
  logic             boundary;
  logic [7:0]       rd_byte;

  assign frm_valid = (state == ST_SEND);
  assign frm_mat   = idx[MAT_W-1:0];
  assign frm_row   = idx[IDX_W-1:MAT_W];
  assign frm_last  = (idx == IDX_W'(BYTE_N - 1));
  assign frm_data  = blank ? 8'h00 : rd_byte;
  assign boundary  = (state == ST_WAIT) && drv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_SEND;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_SEND: if (frm_ready) begin
          if (frm_last) begin
            state <= ST_WAIT;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_WAIT: if (drv_done) state <= ST_SEND;
        default: state <= ST_SEND;
      endcase
    end
  end

  sfe_colbuf #(.STR_N(STR_N), .STR_COLS(STR_COLS), .MAT_N(MAT_N)) u_buf (
    .clk(clk), .we(col_we), .wstr(col_wstr), .wcol(col_wcol), .wdata(col_wdata),
    .rd_str(str_sel), .rd_off(off), .rd_mat(frm_mat), .rd_row(frm_row),
    .rd_byte(rd_byte)
  );

  sfe_levels #(.SPD_MAX(SPD_MAX), .SPD_INIT(SPD_INIT), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .speed_up(speed_up), .speed_dn(speed_dn),
    .bright_up(bright_up), .spd(spd_q), .lvl_upd(lvl_upd), .lvl_val(lvl_val)
  );

  sfe_pacer #(.STR_N(STR_N), .STR_COLS(STR_COLS), .SPD_MAX(SPD_MAX)) u_pace (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .mode(scroll_mode),
    .spd(spd_q), .str_next(str_next), .blink_tgl(blink_tgl),
    .off(off), .str_sel(str_sel), .blank(blank)
  );
endmodule

// File: rtl/sfe_scroll_engine_chk.sv
module sfe_scroll_engine_chk #(
  parameter int MAT_W   = 2,
  parameter int MAT_N   = 4,
  parameter int SPD_W   = 4,
  parameter int SPD_MAX = 15,
  parameter int LVL_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [7:0]       frm_data,
  input logic [2:0]       frm_row,
  input logic [MAT_W-1:0] frm_mat,
  input logic             frm_last,
  input logic             drv_done,
  input logic             col_we,
  input logic             bright_up,
  input logic             lvl_upd,
  input logic [LVL_W-1:0] lvl_val,
  input logic [SPD_W-1:0] spd,
  input logic             blank
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready && !col_we) |=>
      (frm_valid && $stable(frm_data) && $stable(frm_row) && $stable(frm_mat)));

  a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && frm_last) |=> !frm_valid);

  a_r10_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !drv_done) |=> !frm_valid);

  a_r1_last_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_last) |-> (frm_row == 3'd7 && frm_mat == MAT_W'(MAT_N - 1)));

  a_r7_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bright_up |=> lvl_upd);

  a_r7_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_upd |-> (lvl_val == LVL_W'($past(lvl_val) + LVL_W'(1))));

  a_r6_speed_range: assert property (@(posedge clk) disable iff (!rst_n)
    (spd >= SPD_W'(1) && spd <= SPD_W'(SPD_MAX)));

  a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && frm_valid) |-> (frm_data == 8'h00));
endmodule

bind sfe_scroll_engine sfe_scroll_engine_chk #(
  .MAT_W(MAT_W), .MAT_N(MAT_N), .SPD_W(SPD_W), .SPD_MAX(SPD_MAX), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_data(frm_data), .frm_row(frm_row), .frm_mat(frm_mat), .frm_last(frm_last),
  .drv_done(drv_done), .col_we(col_we), .bright_up(bright_up),
  .lvl_upd(lvl_upd), .lvl_val(lvl_val), .spd(spd_q), .blank(blank)
);

// File: tb/test_sfe_scroll_engine.sv
module test_sfe_scroll_engine;
  localparam int NCOL = 64;
  localparam int NSTR = 2;
  localparam int NV   = 5;
  localparam int V_MODE [NV] = '{1, 2, 0, 1, 3};
  localparam int V_NF   [NV] = '{8, 12, 8, 4, 4};
  localparam int V_OFF  [NV] = '{2, 63, 63, 0, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       col_we = 1'b0;
  logic [0:0] col_wstr = '0;
  logic [5:0] col_wcol = '0;
  logic [7:0] col_wdata = '0;
  logic [1:0] scroll_mode = 2'd0;
  logic       speed_up = 1'b0, speed_dn = 1'b0, bright_up = 1'b0;
  logic       blink_tgl = 1'b0, str_next = 1'b0;
  logic       frm_valid, frm_ready = 1'b0, frm_last;
  logic [7:0] frm_data;
  logic [2:0] frm_row;
  logic [1:0] frm_mat;
  logic       drv_done = 1'b0;
  logic       lvl_upd;
  logic [3:0] lvl_val;

  always #10 clk = ~clk;

  sfe_scroll_engine i_sfe_scroll_engine (
    .clk(clk), .rst_n(rst_n), .col_we(col_we), .col_wstr(col_wstr),
    .col_wcol(col_wcol), .col_wdata(col_wdata), .scroll_mode(scroll_mode),
    .speed_up(speed_up), .speed_dn(speed_dn), .bright_up(bright_up),
    .blink_tgl(blink_tgl), .str_next(str_next), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_data(frm_data), .frm_row(frm_row),
    .frm_mat(frm_mat), .frm_last(frm_last), .drv_done(drv_done),
    .lvl_upd(lvl_upd), .lvl_val(lvl_val)
  );

  int errs = 0, checks = 0, cyc = 0, blank_frames = 0;
  int m_off = 0, m_str = 0, m_rep = 0, m_spd = 4;
  bit m_blink = 0, m_phase = 0, m_spend = 0, m_bpend = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(int s, int c);
    logic [5:0] c6;
    c6 = c[5:0];
    return {s[0], c6, 1'b1} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_byte(int s, int off, bit blk, int row, int mat);
    logic [7:0] r, p;
    for (int b = 0; b < 8; b++) begin
      p = pix(s, (off + mat * 8 + 7 - b) % NCOL);
      r[b] = p[row];
    end
    return blk ? 8'h00 : r;
  endfunction

  // frame boundary model (R2 R3 R4 R5 R8 R9)
  task automatic model_boundary();
    if (m_spend) begin
      m_str = (m_str + 1) % NSTR; m_off = 0; m_rep = 0;
    end else if (m_rep + 1 >= m_spd) begin
      m_rep = 0; m_phase = !m_phase;
      if (scroll_mode == 2'd1) m_off = (m_off + 1) % NCOL;
      else if (scroll_mode == 2'd2) m_off = (m_off + NCOL - 1) % NCOL;
    end else m_rep++;
    if (m_bpend) begin m_blink = !m_blink; m_phase = 0; end
    m_spend = 0; m_bpend = 0;
  endtask

  task automatic run_frame(string req);
    logic [7:0] got [32];
    int n = 0, bad = -1;
    bit tags_ok = 1;
    bit blk = m_blink && m_phase;
    @(negedge clk);
    frm_ready = 1'b1;
    while (n < 32) begin
      if (frm_valid) begin
        got[n] = frm_data;
        if (frm_row != 3'(n / 4) || frm_mat != 2'(n % 4) || frm_last != (n == 31)) tags_ok = 0;
        n++;
      end
      @(negedge clk);
    end
    frm_ready = 1'b0;
    for (int k = 0; k < 32; k++)
      if (bad < 0 && got[k] != exp_byte(m_str, m_off, blk, k / 4, k % 4)) bad = k;
    if (bad >= 0)
      chk(0, req, $sformatf("byte %0d (off %0d str %0d)", bad, m_off, m_str),
          got[bad], exp_byte(m_str, m_off, blk, bad / 4, bad % 4));
    else chk(1, req, "frame", 0, 0);
    if (!tags_ok) chk(0, "R1", "row/matrix/last tags", 0, 1);
    if (blk) blank_frames++;
    repeat (2) begin
      if (frm_valid) chk(0, "R10", "valid before drv_done", 1, 0);
      @(negedge clk);
    end
    drv_done = 1'b1;
    @(negedge clk);
    drv_done = 1'b0;
    model_boundary();
  endtask

  task automatic press(int which);
    @(negedge clk);
    case (which)
      0: begin speed_up = 1'b1; if (m_spd < 15) m_spd++; end
      1: begin speed_dn = 1'b1; if (m_spd > 1) m_spd--; end
      2: begin str_next = 1'b1; m_spend = 1; end
      3: begin blink_tgl = 1'b1; m_bpend = 1; end
      default: bright_up = 1'b1;
    endcase
    @(negedge clk);
    speed_up = 1'b0; speed_dn = 1'b0; str_next = 1'b0;
    blink_tgl = 1'b0; bright_up = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(frm_valid == 1'b1, "R11", "valid after reset", frm_valid, 1);
    chk(frm_row == 3'd0 && frm_mat == 2'd0, "R11", "first byte tags", {frm_row, frm_mat}, 0);
    chk(lvl_val == 4'd0 && lvl_upd == 1'b0, "R11", "level after reset", lvl_val, 0);
    // load strings
    for (int s = 0; s < NSTR; s++)
      for (int c = 0; c < NCOL; c++) begin
        col_we = 1'b1; col_wstr = 1'(s); col_wcol = 6'(c); col_wdata = pix(s, c);
        @(negedge clk);
      end
    col_we = 1'b0;

    // table walk: R2 R3 R4 R5 with default speed 4
    for (int v = 0; v < NV; v++) begin
      scroll_mode = 2'(V_MODE[v]);
      for (int f = 0; f < V_NF[v]; f++) run_frame("R2/R3/R4/R5");
      chk(m_off == V_OFF[v], "R5", $sformatf("vector %0d offset", v), m_off, V_OFF[v]);
    end

    // R10 stall: byte and tags stay fixed with ready low
    @(negedge clk);
    d0 = frm_data;
    repeat (4) @(negedge clk);
    chk(frm_valid && frm_data == d0 && frm_row == 3'd0, "R10", "stalled byte", frm_data, d0);
    chk(d0 == exp_byte(m_str, m_off, 0, 0, 0), "R10", "stalled byte value", d0,
        exp_byte(m_str, m_off, 0, 0, 0));

    // R6 lower clamp: 6 lower pulses from 4 leave speed 1
    for (int k = 0; k < 6; k++) press(1);
    scroll_mode = 2'd2;
    for (int f = 0; f < 3; f++) run_frame("R6 speed 1 R3 right");
    chk(m_off == 61, "R6", "offset after 3 right steps", m_off, 61);
    // R6 upper clamp: 20 raise pulses leave speed 15
    for (int k = 0; k < 20; k++) press(0);
    scroll_mode = 2'd1;
    for (int f = 0; f < 16; f++) run_frame("R6 speed 15");
    chk(m_off == 62 && m_rep == 1, "R6", "one step in 16 frames", m_off, 62);
    for (int k = 0; k < 13; k++) press(1); // speed 2

    // R8 string select at boundary
    press(2);
    run_frame("R8 pending select");
    run_frame("R8 new string");
    chk(m_str == 1, "R8", "string index", m_str, 1);
    press(2);
    run_frame("R8 pending wrap");
    run_frame("R8 wrapped string");
    chk(m_str == 0, "R8", "string wrap", m_str, 0);

    // R9 blink with speed 1
    press(1);
    press(3);
    for (int f = 0; f < 5; f++) run_frame("R9 blink");
    chk(blank_frames == 2, "R9", "blank frame count", blank_frames, 2);
    press(3);
    for (int f = 0; f < 3; f++) run_frame("R9 blink off");
    chk(blank_frames == 2, "R9", "no blank after off", blank_frames, 2);

    // R7 brightness steps and wrap
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      bright_up = 1'b1;
      @(negedge clk);
      bright_up = 1'b0;
      if (k == 16 || k == 17 || k == 1)
        chk(lvl_upd == 1'b1 && lvl_val == 4'(k % 16), "R7", $sformatf("level after press %0d", k),
            lvl_val, k % 16);
      @(negedge clk);
      if (k == 1) chk(lvl_upd == 1'b0, "R7", "strobe is one cycle", lvl_upd, 0);
    end
    finish_run();
  end
endmodule